// File: doc/BRIEF.md
# IDE PIO cycle timing generator

This block sequences the control strobes for a single programmed-I/O transfer on a parallel IDE channel. A transfer runs through three phases, each a whole number of host bus clocks long. First comes address setup, with the address marked valid and no strobe. Next comes the active phase, where exactly one of the read or write strobes is driven. Last comes recovery, where the strobe is released and the channel waits before it can run the next transfer. The block is meant for host bus clocks between 25 and 33 MHz. Software derives each field from a nanosecond time: it rounds up to whole clocks and subtracts one.

The master drive and the slave drive each have three timing bytes: one for 16-bit reads, one for 16-bit writes and one for 8-bit command-register accesses. In each byte the high nibble is the active count and the low nibble is the recovery count. Each drive also has an address-setup nibble, and both nibbles share one setup word. At acceptance, the drive select, the direction and the access width of the request pick one set of timing fields. The sequencer holds that set until the transfer ends, so a register write made while a transfer runs changes only later transfers.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset every field holds 15. The block is idle (req_ready=1, addr_valid=0, both strobes low, done low), and a transfer on an unprogrammed drive lasts 16+16+16 clocks.
- R2: A field value N gives a phase that lasts exactly N+1 clocks. The transfer takes setup+active+recovery+3 clocks from the cycle after acceptance to the end of recovery.
- R3: During the setup phase addr_valid is high and both strobes are low.
- R4: During the active phase only the strobe that matches req_write is high: rd_strobe when req_write=0, wr_strobe when req_write=1.
- R5: During recovery both strobes are low and addr_valid stays high. done is high for exactly the last recovery clock, and in the clock after it the block is idle.
- R6: Write port kinds are wr_kind 0 for the setup nibble, 1 for the 16-bit read byte, 2 for the 16-bit write byte and 3 for the 8-bit byte. A timing byte holds active in bits [7:4] and recovery in bits [3:0]. When req_byte=1 the transfer uses the 8-bit byte. Otherwise it uses the read byte or the write byte, chosen by req_write. All of these belong to the drive given by req_drive (0 = master, 1 = slave).
- R7: The master setup nibble is bits [3:0] and the slave nibble is bits [7:4] of one shared setup word. A setup write to one drive leaves the other drive's nibble unchanged.
- R8: A request is accepted only in a clock where req_ready is high, and req_ready is high only while the block is idle. A request that is asserted during a transfer, including in its done clock, is ignored.
- R9: A transfer uses the register values held at its acceptance edge. A write made in the acceptance clock or during the transfer applies from the next transfer.
- R10: rd_strobe and wr_strobe are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | host bus clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_drive | input | 1 | drive targeted by the write (0 master, 1 slave) |
| wr_kind | input | 2 | which register is written (see R6) |
| wr_data | input | 8 | write data; setup writes use bits [3:0] |
| req_valid | input | 1 | transfer request |
| req_drive | input | 1 | drive of the transfer |
| req_write | input | 1 | 1 write, 0 read |
| req_byte | input | 1 | 1 for an 8-bit command access |
| req_ready | output | 1 | idle, request can be taken |
| addr_valid | output | 1 | address phase and transfer in progress |
| rd_strobe | output | 1 | read strobe, active high |
| wr_strobe | output | 1 | write strobe, active high |
| done | output | 1 | one-clock pulse in the last recovery clock |

## Verification
Two functions can coincide in one cycle. A register write can land in the same clock that a request is accepted, and a new request can arrive in the done clock of the previous transfer. The bench writes the selected drive's timing byte in the acceptance clock and writes mid-transfer. It requires the running transfer to keep the old phase lengths and the following transfer to use the new ones. It also raises a stray request during busy clocks, including the done clock, and requires the channel to come back idle with no new address phase.

// File: rtl/pio_tim_pkg.sv
package pio_tim_pkg;
  parameter int NIB_W  = 4;
  localparam int TB_W  = 2 * NIB_W;
  localparam int NUM_DRV = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} phase_e;
  typedef enum logic [1:0] {WK_SETUP = 2'd0, WK_RD16 = 2'd1, WK_WR16 = 2'd2, WK_BYTE8 = 2'd3} wkind_e;

  typedef struct packed {
    logic [NIB_W-1:0] setup;
    logic [NIB_W-1:0] act;
    logic [NIB_W-1:0] rec;
  } xfer_tim_t;

  function automatic logic [NIB_W-1:0] act_of(input logic [TB_W-1:0] b);
    return b[TB_W-1:NIB_W];
  endfunction

  function automatic logic [NIB_W-1:0] rec_of(input logic [TB_W-1:0] b);
    return b[NIB_W-1:0];
  endfunction

  // Replace one drive's nibble of the shared setup word, keep the other.
  function automatic logic [TB_W-1:0] merge_nib(input logic [TB_W-1:0] word,
                                                input logic drv,
                                                input logic [NIB_W-1:0] val);
    logic [TB_W-1:0] r;
    r = word;
    if (drv) r[TB_W-1:NIB_W] = val;
    else     r[NIB_W-1:0]    = val;
    return r;
  endfunction
endpackage

// File: rtl/pio_tim_regs.sv
module pio_tim_regs
  import pio_tim_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_drive,
  input  logic [1:0]      wr_kind,
  input  logic [TB_W-1:0] wr_data,
  input  logic            sel_drive,
  input  logic            sel_write,
  input  logic            sel_byte,
  output xfer_tim_t       tim
);
  logic [TB_W-1:0] setup_word;
  logic [TB_W-1:0] rd16 [NUM_DRV];
  logic [TB_W-1:0] wr16 [NUM_DRV];
  logic [TB_W-1:0] byt8 [NUM_DRV];

  wire setup_wr = wr_en && (wr_kind == WK_SETUP);

  always_ff @(posedge clk) begin
    if (!rst_n)        setup_word <= '1;
    else if (setup_wr) setup_word <= merge_nib(setup_word, wr_drive, wr_data[NIB_W-1:0]);
  end

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    wire hit = wr_en && (wr_drive == g[0]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd16[g] <= '1;
        wr16[g] <= '1;
        byt8[g] <= '1;
      end else if (hit) begin
        if (wr_kind == WK_RD16)  rd16[g] <= wr_data;
        if (wr_kind == WK_WR16)  wr16[g] <= wr_data;
        if (wr_kind == WK_BYTE8) byt8[g] <= wr_data;
      end
    end
  end

  logic [TB_W-1:0] chosen;
  always_comb begin
    if (sel_byte)       chosen = byt8[sel_drive];
    else if (sel_write) chosen = wr16[sel_drive];
    else                chosen = rd16[sel_drive];
    tim.setup = sel_drive ? setup_word[TB_W-1:NIB_W] : setup_word[NIB_W-1:0];
    tim.act   = act_of(chosen);
    tim.rec   = rec_of(chosen);
  end

  // R7: a setup write to one drive leaves the other nibble alone
  p_master_keeps_slave_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_wr && !wr_drive) |=> (setup_word[TB_W-1:NIB_W] == $past(setup_word[TB_W-1:NIB_W])));
  p_slave_keeps_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_wr && wr_drive) |=> (setup_word[NIB_W-1:0] == $past(setup_word[NIB_W-1:0])));
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_tim_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      req_write,
  input  xfer_tim_t tim,
  output logic      req_ready,
  output logic      addr_valid,
  output logic      rd_strobe,
  output logic      wr_strobe,
  output logic      done
);
  phase_e           phase;
  logic [NIB_W-1:0] cnt;
  logic [NIB_W-1:0] lat_act;
  logic [NIB_W-1:0] lat_rec;
  logic             lat_write;

  wire accept    = req_valid && (phase == PH_IDLE);
  wire phase_end = (phase != PH_IDLE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      lat_act   <= '1;
      lat_rec   <= '1;
      lat_write <= 1'b0;
    end else if (accept) begin
      phase     <= PH_SETUP;
      cnt       <= tim.setup;
      lat_act   <= tim.act;
      lat_rec   <= tim.rec;
      lat_write <= req_write;
    end else if (phase_end) begin
      case (phase)
        PH_SETUP:  begin phase <= PH_ACTIVE; cnt <= lat_act; end
        PH_ACTIVE: begin phase <= PH_RECOV;  cnt <= lat_rec; end
        default:   begin phase <= PH_IDLE;   cnt <= '0;      end
      endcase
    end else if (phase != PH_IDLE) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    req_ready  = (phase == PH_IDLE);
    addr_valid = (phase != PH_IDLE);
    rd_strobe  = (phase == PH_ACTIVE) && !lat_write;
    wr_strobe  = (phase == PH_ACTIVE) &&  lat_write;
    done       = (phase == PH_RECOV) && (cnt == '0);
  end

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));
  p_setup_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |-> (addr_valid && !rd_strobe && !wr_strobe));
  p_accept_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (phase == PH_SETUP && addr_valid && !req_ready));
  p_dir_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACTIVE) |-> (lat_write ? (wr_strobe && !rd_strobe) : (rd_strobe && !wr_strobe)));
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != PH_IDLE) && !phase_end) |=> (phase == $past(phase)));
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !addr_valid && !done));
  p_recov_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECOV) |-> (addr_valid && !rd_strobe && !wr_strobe));
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_tim_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_drive,
  input  logic [1:0]      wr_kind,
  input  logic [TB_W-1:0] wr_data,
  input  logic            req_valid,
  input  logic            req_drive,
  input  logic            req_write,
  input  logic            req_byte,
  output logic            req_ready,
  output logic            addr_valid,
  output logic            rd_strobe,
  output logic            wr_strobe,
  output logic            done
);
  xfer_tim_t sel_tim;

  pio_tim_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_drive  (wr_drive),
    .wr_kind   (wr_kind),
    .wr_data   (wr_data),
    .sel_drive (req_drive),
    .sel_write (req_write),
    .sel_byte  (req_byte),
    .tim       (sel_tim)
  );

  pio_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .tim        (sel_tim),
    .req_ready  (req_ready),
    .addr_valid (addr_valid),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .done       (done)
  );
endmodule

// File: tb/pio_strobe_gen_tb.sv
module pio_strobe_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_drive = 1'b0;
  logic [1:0] wr_kind = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic req_valid = 1'b0, req_drive = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic req_ready, addr_valid, rd_strobe, wr_strobe, done;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // bench model of the programmed fields
  logic [7:0] m_setw;
  logic [7:0] m_rd [2];
  logic [7:0] m_wr [2];
  logic [7:0] m_b8 [2];

  always #4 clk = ~clk;  // 125 MHz

  pio_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_drive(wr_drive), .wr_kind(wr_kind),
    .wr_data(wr_data), .req_valid(req_valid), .req_drive(req_drive), .req_write(req_write),
    .req_byte(req_byte), .req_ready(req_ready), .addr_valid(addr_valid),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .done(done));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected < 150000)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // model update, restated from R6/R7
  task automatic model_wr(input logic d, input logic [1:0] k, input logic [7:0] v);
    case (k)
      2'd0: if (d) m_setw[7:4] = v[3:0]; else m_setw[3:0] = v[3:0];
      2'd1: m_rd[d] = v;
      2'd2: m_wr[d] = v;
      default: m_b8[d] = v;
    endcase
  endtask

  task automatic wr_reg(input logic d, input logic [1:0] k, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_drive = d; wr_kind = k; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(d, k, v);
  endtask

  function automatic logic [7:0] pick_byte(input logic d, input logic w, input logic b);
    if (b) return m_b8[d];
    return w ? m_wr[d] : m_rd[d];
  endfunction

  // mode: 0 plain, 1 write mid-transfer, 2 write in accept cycle, 3 stray request
  task automatic xfer(input string tag, input logic d, input logic w, input logic b,
                      input int mode, input logic wd, input logic [1:0] wk, input logic [7:0] wv);
    int s, a, r, total, bad, both;
    logic [7:0] tb;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    s = d ? int'(m_setw[7:4]) : int'(m_setw[3:0]);
    tb = pick_byte(d, w, b);
    a = int'(tb[7:4]); r = int'(tb[3:0]);
    total = s + a + r + 3;
    req_valid = 1'b1; req_drive = d; req_write = w; req_byte = b;
    if (mode == 2) begin wr_en = 1'b1; wr_drive = wd; wr_kind = wk; wr_data = wv; end
    @(negedge clk);
    req_valid = 1'b0;
    if (mode == 2) begin wr_en = 1'b0; model_wr(wd, wk, wv); end
    bad = 0; both = 0;
    for (int i = 0; i < total; i++) begin
      logic [4:0] got, exp;
      bit act_ph;
      act_ph = (i > s) && (i <= s + a + 1);
      got = {req_ready, addr_valid, rd_strobe, wr_strobe, done};
      exp = {1'b0, 1'b1, act_ph && !w, act_ph && w, i == total - 1};
      if (rd_strobe && wr_strobe) both++;
      if (got != exp) begin
        bad++;
        if (i <= s)      chk("R3", int'(got), int'(exp), "setup-phase outputs");
        else if (act_ph) chk("R4", int'(got), int'(exp), "active-phase outputs");
        else             chk("R5", int'(got), int'(exp), "recovery-phase outputs");
      end
      if (mode == 1 && i == 1) begin wr_en = 1'b1; wr_drive = wd; wr_kind = wk; wr_data = wv; end
      if (mode == 1 && i == 2) begin wr_en = 1'b0; model_wr(wd, wk, wv); end
      if (mode == 3 && (i == 2 || i == total - 1)) begin
        req_valid = 1'b1; req_drive = ~d; req_write = ~w; req_byte = 1'b0;
      end
      if (mode == 3 && i == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(tag, bad, 0, "mismatching cycles over transfer");
    chk("R10", both, 0, "cycles with both strobes high");
    chk("R5", int'({req_ready, addr_valid, done}), 3'b100, "idle after done");
    if (mode == 3) begin
      @(negedge clk);
      chk("R8", int'({req_ready, addr_valid}), 2'b10, "stray request ignored");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_setw = 8'hFF;
    for (int k = 0; k < 2; k++) begin m_rd[k] = 8'hFF; m_wr[k] = 8'hFF; m_b8[k] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'({req_ready, addr_valid, rd_strobe, wr_strobe, done}), 5'b10000, "reset outputs");
    xfer("R1", 1'b0, 1'b0, 1'b0, 0, 1'b0, 2'd0, 8'd0);
    xfer("R1", 1'b1, 1'b1, 1'b1, 0, 1'b0, 2'd0, 8'd0);

    // R2: minimum fields
    wr_reg(1'b0, 2'd0, 8'h00); wr_reg(1'b0, 2'd1, 8'h00);
    xfer("R2", 1'b0, 1'b0, 1'b0, 0, 1'b0, 2'd0, 8'd0);

    // R6: byte selection by width and direction
    wr_reg(1'b0, 2'd0, 8'h02);
    wr_reg(1'b0, 2'd1, 8'h21); wr_reg(1'b0, 2'd2, 8'h53); wr_reg(1'b0, 2'd3, 8'h7A);
    xfer("R6", 1'b0, 1'b0, 1'b0, 0, 1'b0, 2'd0, 8'd0);
    xfer("R6", 1'b0, 1'b1, 1'b0, 0, 1'b0, 2'd0, 8'd0);
    xfer("R6", 1'b0, 1'b0, 1'b1, 0, 1'b0, 2'd0, 8'd0);
    xfer("R6", 1'b1, 1'b0, 1'b0, 0, 1'b0, 2'd0, 8'd0);

    // R7: nibbles stay separate
    wr_reg(1'b1, 2'd0, 8'hF5);
    xfer("R7", 1'b0, 1'b1, 1'b0, 0, 1'b0, 2'd0, 8'd0);
    wr_reg(1'b0, 2'd0, 8'hE1);
    xfer("R7", 1'b1, 1'b1, 1'b0, 0, 1'b0, 2'd0, 8'd0);
    xfer("R7", 1'b0, 1'b0, 1'b0, 0, 1'b0, 2'd0, 8'd0);

    // R9: writes during and at acceptance apply next time
    xfer("R9", 1'b0, 1'b0, 1'b0, 1, 1'b0, 2'd1, 8'h34);
    xfer("R9", 1'b0, 1'b0, 1'b0, 0, 1'b0, 2'd0, 8'd0);
    xfer("R9", 1'b0, 1'b1, 1'b0, 2, 1'b0, 2'd2, 8'h12);
    xfer("R9", 1'b0, 1'b1, 1'b0, 0, 1'b0, 2'd0, 8'd0);
    xfer("R9", 1'b0, 1'b0, 1'b0, 2, 1'b0, 2'd0, 8'h09);
    xfer("R9", 1'b0, 1'b0, 1'b0, 0, 1'b0, 2'd0, 8'd0);

    // R8: stray requests while busy, including a minimum-length transfer
    xfer("R8", 1'b1, 1'b0, 1'b0, 3, 1'b0, 2'd0, 8'd0);
    wr_reg(1'b1, 2'd0, 8'h00); wr_reg(1'b1, 2'd3, 8'h00);
    xfer("R8", 1'b1, 1'b1, 1'b1, 3, 1'b0, 2'd0, 8'd0);

    // random mix
    for (int n = 0; n < 250; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      if (rv[3:2] == 2'b00) wr_reg(rv[4], rv[6:5], rv[15:8]);
      xfer("R2", rv[16], rv[17], rv[18], int'(rv[21:20]), rv[22], rv[24:23], rv[31:24]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule